// File: doc/BRIEF.md
# Vectored Two-Output Interrupt Controller

This block gathers 96 level-sensitive interrupt sources, organised as three 32-bit words, and turns them into two request lines for a processor. The normal request line is raised when any source is active. The fast request line is raised only by active sources whose routing bit is set. A source is active when its input is high and its mask bit is clear. For each source, the pending state is simply its input level: it follows the input and is not latched.

The block also publishes a vector value. This is the byte offset of the lowest-numbered active source, so software can index a handler table of 32-bit entries with it directly. The outputs are recomputed combinationally from the source inputs and the register contents. A change at an input, or a register write, shows up on the pins in the same cycle it takes effect.

Software reaches the block through a plain 32-bit register port with single-cycle access. Reads are combinational and writes land on the next clock edge. The register window spans 0x400 bytes. It also holds scratch registers: a word-aligned base address, a protection word and an NMI control word. These registers are storage only; the block logic does not act on them.

Top module: `vec_intc`

## Requirements
- R1: Reads of the pending words (0x10, 0x14, 0x18 for sources 0-31, 32-63, 64-95) return the current source levels, and writes to those offsets change nothing.
- R2: `irq_o` is high exactly when some source has its input high and its mask bit (mask words 0x50/0x54/0x58) clear.
- R3: `fiq_o` is high exactly when some source has its input high, its mask bit clear and its routing bit (route words 0x30/0x34/0x38) set.
- R4: The vector register at 0x00 reads 4 × the number of the lowest-numbered active source, with source 0 counted first. It reads 0 when no source is active.
- R5: Route, enable (0x40/0x44/0x48), mask, protection (0x08) and NMI control (0x0C) registers read back the last value written. Each word of a three-word bank is selected by address bits [3:2].
- R6: A write to the base-address register (0x04) stores the value with bits [1:0] forced to 0.
- R7: The fast-pending words (0x20/0x24/0x28) clear every bit that is written as 1, and none of their bits is ever set by the block.
- R8: An offset that maps to no register reads 0, and a write to it alters no register. Such offsets include any address with bits [1:0] nonzero and the fourth slot (+0xC) of a bank.
- R9: After reset every register reads 0 and both request lines are low.
- R10: The vector register is read-only, and writes to 0x00 leave its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 96 | Source levels, bit n is source n |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is a vector decision that crosses a word boundary. The lowest raw source sits in one word, but masking hides it, so the winner lies in a later word. A plain priority scan that ignores the mask, or one that stops at the first word holding any pending bit, would report the wrong source. The stimulus builds this case on purpose: it masks all of word 0 while sources 0 and 32 are both high, and it raises sources 40 and 70 together. Randomised rounds with sparse masks and routing bits then cover mixed patterns against a bench model that scans all 96 sources one by one.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int WORD_W     = 32;
  localparam int IDX_W      = $clog2(WORD_W);
  localparam int REG_ADDR_W = 10;
  localparam int PAGE_W     = REG_ADDR_W - 4;

  // 16-byte pages; page 0 holds the scalar registers
  localparam logic [PAGE_W-1:0] PG_SCALAR = PAGE_W'(0);
  localparam logic [PAGE_W-1:0] PG_PEND   = PAGE_W'(1);
  localparam logic [PAGE_W-1:0] PG_FIQP   = PAGE_W'(2);
  localparam logic [PAGE_W-1:0] PG_ROUTE  = PAGE_W'(3);
  localparam logic [PAGE_W-1:0] PG_EN     = PAGE_W'(4);
  localparam logic [PAGE_W-1:0] PG_MASK   = PAGE_W'(5);

  typedef enum logic [3:0] {
    BK_NONE, BK_VEC, BK_BASE, BK_PROT, BK_NMI,
    BK_PEND, BK_FIQP, BK_ROUTE, BK_EN, BK_MASK
  } bank_e;

  typedef struct packed {
    bank_e      bank;
    logic [1:0] idx;
  } dec_t;

  // Address decode; anything not mapped comes back as BK_NONE
  function automatic dec_t decode_addr(input logic [REG_ADDR_W-1:0] a,
                                       input int nwords);
    dec_t d;
    d.bank = BK_NONE;
    d.idx  = a[3:2];
    if (a[1:0] == 2'b00) begin
      if (a[REG_ADDR_W-1:4] == PG_SCALAR) begin
        case (a[3:2])
          2'd0: d.bank = BK_VEC;
          2'd1: d.bank = BK_BASE;
          2'd2: d.bank = BK_PROT;
          default: d.bank = BK_NMI;
        endcase
      end else if (int'(a[3:2]) < nwords) begin
        case (a[REG_ADDR_W-1:4])
          PG_PEND:  d.bank = BK_PEND;
          PG_FIQP:  d.bank = BK_FIQP;
          PG_ROUTE: d.bank = BK_ROUTE;
          PG_EN:    d.bank = BK_EN;
          PG_MASK:  d.bank = BK_MASK;
          default:  d.bank = BK_NONE;
        endcase
      end
    end
    return d;
  endfunction

  // Index of the lowest set bit (0 when none is set)
  function automatic logic [IDX_W-1:0] lowest_set(input logic [WORD_W-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // Byte offset of a source given its word and bit position
  function automatic int vector_of(input int word, input int bitpos);
    return (word * WORD_W + bitpos) * 4;
  endfunction
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_stb,
  input  dec_t                             dec,
  input  logic [WORD_W-1:0]                wdata,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] route_q,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] en_q,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] mask_q,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] fiqp_q,
  output logic [WORD_W-1:0]                base_q,
  output logic [WORD_W-1:0]                prot_q,
  output logic [WORD_W-1:0]                nmi_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else if (wr_stb) begin
      case (dec.bank)
        BK_BASE: base_q <= {wdata[WORD_W-1:2], 2'b00};
        BK_PROT: prot_q <= wdata;
        BK_NMI:  nmi_q  <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] route_r, en_r, mask_r, fiqp_r;
    logic              hit_w;

    assign hit_w = wr_stb && (dec.idx == 2'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        route_r <= '0;
        en_r    <= '0;
        mask_r  <= '0;
        fiqp_r  <= '0;
      end else if (hit_w) begin
        case (dec.bank)
          BK_ROUTE: route_r <= wdata;
          BK_EN:    en_r    <= wdata;
          BK_MASK:  mask_r  <= wdata;
          BK_FIQP:  fiqp_r  <= fiqp_r & ~wdata;
          default: ;
        endcase
      end
    end

    assign route_q[w] = route_r;
    assign en_q[w]    = en_r;
    assign mask_q[w]  = mask_r;
    assign fiqp_q[w]  = fiqp_r;
  end
endmodule

// File: rtl/vic_resolve.sv
module vic_resolve
  import vic_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int VEC_W     = 9
) (
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] pend,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] mask,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] route,
  output logic                             irq_o,
  output logic                             fiq_o,
  output logic [VEC_W-1:0]                 vec_o
);
  logic [NUM_WORDS-1:0]            word_hit;
  logic [NUM_WORDS-1:0]            word_fast;
  logic [NUM_WORDS-1:0][IDX_W-1:0] word_low;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_scan
    logic [WORD_W-1:0] act;
    assign act          = pend[w] & ~mask[w];
    assign word_hit[w]  = |act;
    assign word_fast[w] = |(act & route[w]);
    assign word_low[w]  = lowest_set(act);
  end

  assign irq_o = |word_hit;
  assign fiq_o = |word_fast;

  // Highest word first so the lowest hit word wins
  always_comb begin
    vec_o = '0;
    for (int w = NUM_WORDS - 1; w >= 0; w--) begin
      if (word_hit[w]) vec_o = VEC_W'(vector_of(w, int'(word_low[w])));
    end
  end
endmodule

// File: rtl/vic_rdmux.sv
module vic_rdmux
  import vic_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input  logic                             rd_stb,
  input  dec_t                             dec,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] pend,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] fiqp,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] route,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] en,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] mask,
  input  logic [WORD_W-1:0]                vec,
  input  logic [WORD_W-1:0]                base,
  input  logic [WORD_W-1:0]                prot,
  input  logic [WORD_W-1:0]                nmi,
  output logic [WORD_W-1:0]                rdata
);
  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      case (dec.bank)
        BK_VEC:  rdata = vec;
        BK_BASE: rdata = base;
        BK_PROT: rdata = prot;
        BK_NMI:  rdata = nmi;
        default: begin
          for (int w = 0; w < NUM_WORDS; w++) begin
            if (dec.idx == 2'(w)) begin
              case (dec.bank)
                BK_PEND:  rdata = pend[w];
                BK_FIQP:  rdata = fiqp[w];
                BK_ROUTE: rdata = route[w];
                BK_EN:    rdata = en[w];
                BK_MASK:  rdata = mask[w];
                default:  rdata = '0;
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_WORDS*WORD_W-1:0]   src_i,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [REG_ADDR_W-1:0]         bus_addr,
  input  logic [WORD_W-1:0]             bus_wdata,
  output logic [WORD_W-1:0]             bus_rdata,
  output logic                          irq_o,
  output logic                          fiq_o
);
  localparam int NUM_SRC = NUM_WORDS * WORD_W;
  localparam int VEC_W   = $clog2(NUM_SRC) + 2;

  dec_t                             dec;
  logic                             wr_stb, rd_stb;
  logic [NUM_WORDS-1:0][WORD_W-1:0] pend_w, route_q, en_q, mask_q, fiqp_q;
  logic [WORD_W-1:0]                base_q, prot_q, nmi_q, vec_q;
  logic [VEC_W-1:0]                 vec_raw;

  assign dec    = decode_addr(bus_addr, NUM_WORDS);
  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;
  assign pend_w = src_i;
  assign vec_q  = WORD_W'(vec_raw);

  vic_regs #(.NUM_WORDS(NUM_WORDS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .dec     (dec),
    .wdata   (bus_wdata),
    .route_q (route_q),
    .en_q    (en_q),
    .mask_q  (mask_q),
    .fiqp_q  (fiqp_q),
    .base_q  (base_q),
    .prot_q  (prot_q),
    .nmi_q   (nmi_q)
  );

  vic_resolve #(.NUM_WORDS(NUM_WORDS), .VEC_W(VEC_W)) u_resolve (
    .pend  (pend_w),
    .mask  (mask_q),
    .route (route_q),
    .irq_o (irq_o),
    .fiq_o (fiq_o),
    .vec_o (vec_raw)
  );

  vic_rdmux #(.NUM_WORDS(NUM_WORDS)) u_rdmux (
    .rd_stb (rd_stb),
    .dec    (dec),
    .pend   (pend_w),
    .fiqp   (fiqp_q),
    .route  (route_q),
    .en     (en_q),
    .mask   (mask_q),
    .vec    (vec_q),
    .base   (base_q),
    .prot   (prot_q),
    .nmi    (nmi_q),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
  import vic_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_WORDS*WORD_W-1:0]      src_i,
  input logic [NUM_WORDS-1:0][WORD_W-1:0] mask_w,
  input logic [NUM_WORDS-1:0][WORD_W-1:0] route_w,
  input logic [NUM_WORDS-1:0][WORD_W-1:0] fiqp_w,
  input logic [WORD_W-1:0]                base_w,
  input logic [WORD_W-1:0]                vec_w,
  input logic                             irq_o,
  input logic                             fiq_o,
  input logic                             bus_sel,
  input logic                             bus_wr,
  input logic [REG_ADDR_W-1:0]            bus_addr,
  input logic [WORD_W-1:0]                bus_rdata
);
  localparam int NUM_SRC = NUM_WORDS * WORD_W;
  localparam int SRC_W   = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] act_c;
  logic [SRC_W-1:0]   vec_src;
  assign act_c   = src_i & ~mask_w;
  assign vec_src = vec_w[SRC_W+1:2];

  AST_IRQ_ANY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|act_c)); // R2
  AST_FIQ_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == (|(act_c & route_w))); // R3
  AST_FIQ_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> irq_o); // R3
  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_w == '0)); // R4
  AST_VEC_POINTS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> act_c[vec_src]); // R4
  AST_BASE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    base_w[1:0] == 2'b00); // R6
  AST_FIQP_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (fiqp_w & ~$past(fiqp_w)) == '0); // R7
  AST_UNALIGNED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R8
endmodule

bind vec_intc vec_intc_chk #(.NUM_WORDS(NUM_WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .mask_w    (mask_q),
  .route_w   (route_q),
  .fiqp_w    (fiqp_q),
  .base_w    (base_q),
  .vec_w     (vec_q),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  localparam int NW = 3;
  localparam int NS = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          bsel = 1'b0, bwr = 1'b0;
  logic [9:0]    baddr = '0;
  logic [31:0]   bwdata = '0;
  logic [31:0]   brdata;
  logic          irq, fiq;

  always #10 clk = ~clk;

  vec_intc #(.NUM_WORDS(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_sel(bsel), .bus_wr(bwr),
    .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(brdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  typedef struct {
    int          kind;   // 0: read data, 1: {fiq, irq}
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t queue_q[$];
  event  mon_ev;
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  logic [31:0] m_mask [NW];
  logic [31:0] m_route[NW];

  // Scoreboard monitor
  initial begin
    forever begin
      @(mon_ev);
      while (queue_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = queue_q.pop_front();
        act = (it.kind == 1) ? {30'b0, fiq, irq} : brdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  // Model: scan sources one by one
  function automatic logic [31:0] model_vec();
    for (int i = 0; i < NS; i++)
      if (src[i] && !m_mask[i/32][i%32]) return 32'(i * 4);
    return 32'd0;
  endfunction

  function automatic logic [1:0] model_pins();
    logic a = 1'b0, f = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (src[i] && !m_mask[i/32][i%32]) begin
        a = 1'b1;
        if (m_route[i/32][i%32]) f = 1'b1;
      end
    end
    return {f, a};
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bsel = 1'b1; bwr = 1'b1; baddr = a; bwdata = d;
    @(negedge clk);
    bsel = 1'b0; bwr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bsel = 1'b1; bwr = 1'b0; baddr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    queue_q.push_back(it);
    #5 -> mon_ev;
    #1 bsel = 1'b0;
  endtask

  task automatic pins(input string tag);
    item_t it;
    @(negedge clk);
    it.kind = 1; it.exp = {30'b0, model_pins()}; it.tag = tag;
    queue_q.push_back(it);
    #5 -> mon_ev;
    #1;
  endtask

  task automatic set_src(input logic [NS-1:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic set_mask(input int w, input logic [31:0] v);
    m_mask[w] = v;
    wr(10'(32'h50 + 4*w), v);
  endtask

  task automatic set_route(input int w, input logic [31:0] v);
    m_route[w] = v;
    wr(10'(32'h30 + 4*w), v);
  endtask

  task automatic check_out(input string tag);
    pins({tag, " pins"});
    rd(10'h000, model_vec(), {tag, " vector"});
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++) begin m_mask[w] = '0; m_route[w] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    pins("R9 request lines after reset");
    rd(10'h000, 32'h0, "R9 vector");
    rd(10'h004, 32'h0, "R9 base");
    rd(10'h008, 32'h0, "R9 protect");
    rd(10'h00C, 32'h0, "R9 nmi");
    for (int w = 0; w < NW; w++) begin
      rd(10'(32'h20 + 4*w), 32'h0, "R9 fast pending");
      rd(10'(32'h30 + 4*w), 32'h0, "R9 route");
      rd(10'(32'h40 + 4*w), 32'h0, "R9 enable");
      rd(10'(32'h50 + 4*w), 32'h0, "R9 mask");
    end

    // R5: read-back per word via addr[3:2]
    for (int w = 0; w < NW; w++) begin
      wr(10'(32'h40 + 4*w), 32'h1111_0000 * (w + 1) + 32'h5A);
      set_route(w, 32'h0F0F_0000 >> w);
      set_mask(w, 32'hFFFF_FFFF);
    end
    for (int w = 0; w < NW; w++) begin
      rd(10'(32'h40 + 4*w), 32'h1111_0000 * (w + 1) + 32'h5A, "R5 enable word");
      rd(10'(32'h30 + 4*w), 32'h0F0F_0000 >> w, "R5 route word");
      rd(10'(32'h50 + 4*w), 32'hFFFF_FFFF, "R5 mask word");
    end
    wr(10'h008, 32'hCAFE_F00D);
    wr(10'h00C, 32'h0000_0003);
    rd(10'h008, 32'hCAFE_F00D, "R5 protect");
    rd(10'h00C, 32'h0000_0003, "R5 nmi");

    // R6: base low bits dropped
    wr(10'h004, 32'hFFFF_FFFF);
    rd(10'h004, 32'hFFFF_FFFC, "R6 base");
    wr(10'h004, 32'h1234_5677);
    rd(10'h004, 32'h1234_5674, "R6 base");

    // R1: pending mirrors levels, writes ignored
    set_src({32'hA5A5_0000, 32'h1234_5678, 32'h8000_0001});
    rd(10'h010, 32'h8000_0001, "R1 pending word0");
    rd(10'h014, 32'h1234_5678, "R1 pending word1");
    rd(10'h018, 32'hA5A5_0000, "R1 pending word2");
    wr(10'h014, 32'hFFFF_FFFF);
    wr(10'h010, 32'h0000_0000);
    rd(10'h014, 32'h1234_5678, "R1 pending write ignored");
    rd(10'h010, 32'h8000_0001, "R1 pending write ignored");
    check_out("R2 all masked");

    // R2/R3/R4 directed corners
    for (int w = 0; w < NW; w++) begin set_mask(w, 32'h0); set_route(w, 32'h0); end
    set_src('0);
    check_out("R4 none active");
    set_src(NS'(1));
    check_out("R4 source 0 only");
    set_src({1'b1, {(NS-1){1'b0}}});
    check_out("R4 source 95 only");
    set_route(2, 32'h8000_0000);
    check_out("R3 source 95 routed");
    set_src((NS'(1) << 32) | NS'(1));
    set_mask(0, 32'hFFFF_FFFF);
    check_out("R4 word0 masked, source 32 wins");
    set_mask(0, 32'h0);
    set_src((NS'(1) << 40) | (NS'(1) << 70));
    check_out("R4 sources 40 and 70");
    set_route(1, 32'h0000_0100);
    check_out("R3 source 40 routed");
    set_mask(1, 32'h0000_0100);
    check_out("R2 source 40 masked");

    // R10: vector write ignored
    wr(10'h000, 32'hFFFF_FFFF);
    rd(10'h000, model_vec(), "R10 vector after write");

    // R7: fast-pending write-one-to-clear
    wr(10'h020, 32'hFFFF_FFFF);
    wr(10'h028, 32'h0000_FFFF);
    rd(10'h020, 32'h0, "R7 fast pending word0");
    rd(10'h028, 32'h0, "R7 fast pending word2");

    // R8: unmapped offsets
    wr(10'h05C, 32'hDEAD_BEEF);
    wr(10'h052, 32'hDEAD_BEEF);
    wr(10'h0F0, 32'hDEAD_BEEF);
    rd(10'h05C, 32'h0, "R8 fourth slot read");
    rd(10'h3FC, 32'h0, "R8 top of window");
    rd(10'h012, 32'h0, "R8 unaligned read");
    rd(10'h0F0, 32'h0, "R8 empty page");
    for (int w = 0; w < NW; w++)
      rd(10'(32'h50 + 4*w), m_mask[w], "R8 mask untouched");
    rd(10'h040, 32'h1111_005A, "R8 enable untouched");

    // R2/R3/R4 randomised rounds
    for (int k = 0; k < 24; k++) begin
      for (int w = 0; w < NW; w++) begin
        set_mask(w, $urandom() | $urandom());
        set_route(w, $urandom() & $urandom());
      end
      set_src({$urandom() & $urandom(), $urandom() & $urandom(), $urandom() & $urandom()});
      check_out("R2 R3 R4 random round");
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule